// File: doc/BRIEF.md
# Power-Up Reset Sequencer with Brown-Out Filter

This block generates the internal reset of a small microcontroller core from digital status inputs. It takes a power-on pulse, a supply-good flag from an external voltage comparator and a wake-from-sleep request. It holds the core in reset through three stages:

- a qualified brown-out hold, entered only after a filtered supply dip;
- a power-up delay counted on ticks of a slow internal RC clock;
- an oscillator settling delay counted on oscillator-cycle ticks. This stage runs only for crystal or resonator oscillator modes.

The power-up delay restarts from zero whenever the supply flag drops while it is counting. The oscillator delay follows a power-on event or a wake request, and is never applied after a brown-out.

All state is clocked by one system clock `clk`. `rc_tick` and `osc_tick` are single-cycle enables, already brought into that clock domain. The reset output comes straight from the state register, so it changes only on clock edges. Two sticky flags record whether a power-on or a brown-out reset has happened since the last clear strobe.

Top module: `pwr_reset_seq`

## Requirements
- R1: `core_rst` is 1 in every clock cycle in which the sequencer is not in its run state. A one-cycle `por_pulse` takes it to 1 at the next clock edge from any state and restarts the power-up stage with a cleared count.
- R2: With `cfg_pwrt_off`=0, the power-up stage keeps `core_rst` at 1 until `PWRT_TICKS` cycles with `rc_tick`=1 have been seen while in that stage.
- R3: With `cfg_pwrt_off`=1, the power-up stage is left at the clock edge after it is entered, without waiting for any `rc_tick`.
- R4: When the power-up stage was started by power-on, and `cfg_osc_mode` is 0 (low-power crystal), 1 (standard crystal) or 2 (high-speed crystal), `core_rst` stays 1 for a further `OST_CYCLES` cycles with `osc_tick`=1.
- R5: For `cfg_osc_mode` values 3 to 7 (RC and external-clock modes), the oscillator delay is skipped and run follows the power-up stage directly.
- R6: With `cfg_bod_en`=1 in run or oscillator-delay state, a brown-out reset happens only when `supply_ok` is 0 on `BOD_FILT` consecutive clock edges. A shorter dip leaves `core_rst` at 0 and `flag_bor` unchanged.
- R7: With `cfg_bod_en`=0, `supply_ok` has no effect on `core_rst` or `flag_bor`.
- R8: After a brown-out, `core_rst` stays 1 while `supply_ok`=0. The power-up stage begins at the edge on which `supply_ok` is seen at 1 again. No oscillator delay follows a brown-out, even in a crystal mode.
- R9: With `cfg_bod_en`=1, a single clock of `supply_ok`=0 during the power-up stage returns the sequencer to the brown-out hold. The count is cleared, so a full `PWRT_TICKS` delay follows recovery.
- R10: A `wake_req` pulse in run state enters the oscillator delay for `OST_CYCLES` osc ticks when `cfg_osc_mode` is 0 to 2. For modes 3 to 7 it is ignored and `core_rst` stays 0.
- R11: `flag_por` is set by `por_pulse` and `flag_bor` by entry into the brown-out hold. `flag_clr` clears both. A set in the same cycle as a clear wins.
- R12: While `rst_n`=0: `core_rst`=1, `flag_por`=1 and `flag_bor`=0. Release passes through a two-stage synchronizer, then a power-on sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hard reset, released synchronously |
| por_pulse | input | 1 | One-cycle power-on event |
| supply_ok | input | 1 | 1 while the supply is above the brown-out threshold |
| wake_req | input | 1 | One-cycle wake-from-sleep request |
| rc_tick | input | 1 | Enable pulse, one per internal RC clock period |
| osc_tick | input | 1 | Enable pulse, one per oscillator cycle |
| cfg_bod_en | input | 1 | 1 enables brown-out detection |
| cfg_pwrt_off | input | 1 | 1 bypasses the power-up delay, 0 enables it |
| cfg_osc_mode | input | 3 | Oscillator mode: 0..2 crystal types, 3..7 RC or external |
| flag_clr | input | 1 | Clear strobe for both cause flags |
| core_rst | output | 1 | Active-high internal reset of the core |
| flag_por | output | 1 | Sticky power-on cause flag |
| flag_bor | output | 1 | Sticky brown-out cause flag |

## Verification
The properties assume that `por_pulse`, `wake_req` and `flag_clr` are single-cycle strobes, and that all inputs change only between clock edges. They also assume the configuration inputs are steady whenever the sequencer's timing is being judged. The stimulus drives every input on the falling clock edge, keeps configuration changes to idle periods between scenarios, and issues strobes for one cycle. Supply dips are shaped to land on either side of the filter length. The dip that restarts the power-up stage is issued only after that stage has counted about half its ticks, so a missing restart shows up as a short hold.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_BOR  = 2'd1,
    ST_PWRT = 2'd2,
    ST_OST  = 2'd3
  } seq_state_e;

  localparam int unsigned OSC_MODE_W = 3;

  // Modes 0..2 use a crystal or resonator that needs settling time.
  function automatic logic mode_needs_ost(input logic [OSC_MODE_W-1:0] mode);
    return (mode <= OSC_MODE_W'(2));
  endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/bod_filter.sv
module bod_filter #(
  parameter int unsigned BOD_FILT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic supply_ok,
  output logic trip
);

  localparam int unsigned CW = (BOD_FILT > 1) ? $clog2(BOD_FILT) : 1;
  localparam logic [CW-1:0] LAST = CW'(BOD_FILT - 1);

  logic [CW-1:0] low_cnt_q;
  logic [CW-1:0] low_cnt_d;
  logic          at_last;
  logic          low_now;

  always_comb begin
    low_now = en & ~supply_ok;
    at_last = (low_cnt_q == LAST);
    trip    = low_now & at_last;
    if (!low_now)     low_cnt_d = '0;
    else if (at_last) low_cnt_d = low_cnt_q;
    else              low_cnt_d = low_cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt_q <= '0;
    else        low_cnt_q <= low_cnt_d;
  end

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned LIMIT = 72
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic done
);

  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    done   = tick & ~clr & (cnt_q == LAST);
    cnt_en = clr | tick;
    if (clr || done) cnt_d = '0;
    else             cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pwr_reset_seq.sv
module pwr_reset_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned PWRT_TICKS = 72,
  parameter int unsigned OST_CYCLES = 1024,
  parameter int unsigned BOD_FILT   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  por_pulse,
  input  logic                  supply_ok,
  input  logic                  wake_req,
  input  logic                  rc_tick,
  input  logic                  osc_tick,
  input  logic                  cfg_bod_en,
  input  logic                  cfg_pwrt_off,
  input  logic [OSC_MODE_W-1:0] cfg_osc_mode,
  input  logic                  flag_clr,
  output logic                  core_rst,
  output logic                  flag_por,
  output logic                  flag_bor
);

  logic       rst_i_n;
  seq_state_e state_q, state_d;
  logic       cause_por_q, cause_por_d;
  logic       flag_por_q, flag_por_d;
  logic       flag_bor_q, flag_bor_d;
  logic       bor_trip;
  logic       pwrt_clr, pwrt_tick, pwrt_done;
  logic       ost_clr, ost_tick, ost_done;
  logic       xtal;
  seq_state_e after_pwrt;

  rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  bod_filter #(.BOD_FILT(BOD_FILT)) u_bod_filter (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .en        (cfg_bod_en),
    .supply_ok (supply_ok),
    .trip      (bor_trip)
  );

  assign pwrt_clr  = (state_q != ST_PWRT) | por_pulse;
  assign pwrt_tick = (state_q == ST_PWRT) & rc_tick;
  assign ost_clr   = (state_q != ST_OST) | por_pulse;
  assign ost_tick  = (state_q == ST_OST) & osc_tick;

  tick_counter #(.LIMIT(PWRT_TICKS)) u_pwrt_cnt (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (pwrt_clr),
    .tick  (pwrt_tick),
    .done  (pwrt_done)
  );

  tick_counter #(.LIMIT(OST_CYCLES)) u_ost_cnt (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (ost_clr),
    .tick  (ost_tick),
    .done  (ost_done)
  );

  assign xtal       = mode_needs_ost(cfg_osc_mode);
  assign after_pwrt = (cause_por_q && xtal) ? ST_OST : ST_RUN;

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    cause_por_d = cause_por_q;
    if (por_pulse) begin
      state_d     = ST_PWRT;
      cause_por_d = 1'b1;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (bor_trip) begin
            state_d     = ST_BOR;
            cause_por_d = 1'b0;
          end else if (wake_req && xtal) begin
            state_d = ST_OST;
          end
        end
        ST_OST: begin
          if (bor_trip) begin
            state_d     = ST_BOR;
            cause_por_d = 1'b0;
          end else if (ost_done) begin
            state_d = ST_RUN;
          end
        end
        ST_PWRT: begin
          if (cfg_bod_en && !supply_ok) begin
            state_d     = ST_BOR;
            cause_por_d = 1'b0;
          end else if (cfg_pwrt_off || pwrt_done) begin
            state_d = after_pwrt;
          end
        end
        ST_BOR: begin
          if (supply_ok || !cfg_bod_en) state_d = ST_PWRT;
        end
        default: state_d = ST_PWRT;
      endcase
    end
    flag_por_d = por_pulse | (flag_por_q & ~flag_clr);
    flag_bor_d = ((state_d == ST_BOR) && (state_q != ST_BOR)) | (flag_bor_q & ~flag_clr);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q     <= ST_PWRT;
      cause_por_q <= 1'b1;
      flag_por_q  <= 1'b1;
      flag_bor_q  <= 1'b0;
    end else begin
      state_q     <= state_d;
      cause_por_q <= cause_por_d;
      flag_por_q  <= flag_por_d;
      flag_bor_q  <= flag_bor_d;
    end
  end

  assign core_rst = (state_q != ST_RUN);
  assign flag_por = flag_por_q;
  assign flag_bor = flag_bor_q;

endmodule

// File: rtl/pwr_reset_seq_chk.sv
module pwr_reset_seq_chk #(
  parameter int BOD_FILT = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       por_pulse,
  input logic       supply_ok,
  input logic       wake_req,
  input logic       cfg_bod_en,
  input logic [2:0] cfg_osc_mode,
  input logic       flag_clr,
  input logic       core_rst,
  input logic       flag_por,
  input logic       flag_bor
);

  // Count of consecutive earlier clock edges that saw supply_ok low.
  int low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               low_run <= 0;
    else if (supply_ok)       low_run <= 0;
    else if (low_run < BOD_FILT) low_run <= low_run + 1;
  end

  assert_por_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    por_pulse |=> (core_rst && flag_por));

  assert_short_dip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_rst && !por_pulse && !wake_req && (supply_ok || low_run < BOD_FILT - 1))
      |=> !core_rst);

  assert_bor_flag_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_bor) |-> core_rst);

  assert_bod_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_rst && !cfg_bod_en && !por_pulse && !wake_req) |=> !core_rst);

  assert_wake_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_rst && wake_req && (cfg_osc_mode > 3'd2) && !por_pulse && supply_ok)
      |=> !core_rst);

  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !por_pulse) |=> !flag_por);

endmodule

bind pwr_reset_seq pwr_reset_seq_chk #(.BOD_FILT(BOD_FILT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .por_pulse    (por_pulse),
  .supply_ok    (supply_ok),
  .wake_req     (wake_req),
  .cfg_bod_en   (cfg_bod_en),
  .cfg_osc_mode (cfg_osc_mode),
  .flag_clr     (flag_clr),
  .core_rst     (core_rst),
  .flag_por     (flag_por),
  .flag_bor     (flag_bor)
);

// File: tb/tb_pwr_reset_seq.sv
module tb_pwr_reset_seq;

  localparam int CLK_PERIOD = 10;
  localparam int P  = 12;
  localparam int O  = 64;
  localparam int F  = 4;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n, por_pulse, supply_ok, wake_req, rc_tick, osc_tick;
  logic       cfg_bod_en, cfg_pwrt_off, flag_clr;
  logic [2:0] cfg_osc_mode;
  logic       core_rst, flag_por, flag_bor;

  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 0;

  pwr_reset_seq #(.PWRT_TICKS(P), .OST_CYCLES(O), .BOD_FILT(F)) dut (
    .clk(clk), .rst_n(rst_n), .por_pulse(por_pulse), .supply_ok(supply_ok),
    .wake_req(wake_req), .rc_tick(rc_tick), .osc_tick(osc_tick),
    .cfg_bod_en(cfg_bod_en), .cfg_pwrt_off(cfg_pwrt_off),
    .cfg_osc_mode(cfg_osc_mode), .flag_clr(flag_clr),
    .core_rst(core_rst), .flag_por(flag_por), .flag_bor(flag_bor)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_range(input string tag, input string what, input int act,
                             input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d..%0d", tag, what, act, lo, hi);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // phase: 0 running, 1 waiting for supply, 2 power-up delay, 3 oscillator delay
  int m_phase, m_low, m_rc_seen, m_osc_seen, m_sync;
  bit m_by_por, m_fpor, m_fbor, m_valid = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 2; m_by_por = 1; m_fpor = 1; m_fbor = 0;
      m_low = 0; m_rc_seen = 0; m_osc_seen = 0; m_sync = 0; m_valid = 1;
    end else begin
      if (m_sync == 2) begin
        int  nxt;
        bit  dip_long, crystal, nby;
        dip_long = cfg_bod_en && !supply_ok && (m_low + 1 >= F);
        crystal  = (cfg_osc_mode inside {3'd0, 3'd1, 3'd2});
        nxt = m_phase;
        nby = m_by_por;
        if (por_pulse) begin
          nxt = 2; nby = 1;
        end else if (m_phase == 0) begin
          if (dip_long) begin nxt = 1; nby = 0; end
          else if (wake_req && crystal) nxt = 3;
        end else if (m_phase == 3) begin
          if (dip_long) begin nxt = 1; nby = 0; end
          else if (osc_tick && m_osc_seen + 1 == O) nxt = 0;
        end else if (m_phase == 2) begin
          if (cfg_bod_en && !supply_ok) begin nxt = 1; nby = 0; end
          else if (cfg_pwrt_off || (rc_tick && m_rc_seen + 1 == P))
            nxt = (m_by_por && crystal) ? 3 : 0;
        end else begin
          if (supply_ok || !cfg_bod_en) nxt = 2;
        end
        m_low = (cfg_bod_en && !supply_ok) ? ((m_low < F) ? m_low + 1 : F) : 0;
        m_rc_seen  = (nxt == 2 && m_phase == 2 && !por_pulse) ? m_rc_seen + int'(rc_tick) : 0;
        m_osc_seen = (nxt == 3 && m_phase == 3 && !por_pulse) ? m_osc_seen + int'(osc_tick) : 0;
        m_fbor = (nxt == 1 && m_phase != 1) || (m_fbor && !flag_clr);
        m_fpor = por_pulse || (m_fpor && !flag_clr);
        m_phase = nxt;
        m_by_por = nby;
      end
      if (m_sync < 2) m_sync++;
    end
  end

  // Cycle-by-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (m_valid && !done_flag) begin
      check("R1", "core_rst vs model", int'(core_rst), int'(m_phase != 0));
      check("R11", "flag_por vs model", int'(flag_por), int'(m_fpor));
      check("R11", "flag_bor vs model", int'(flag_bor), int'(m_fbor));
    end
  end

  // ---------------- tick sources ----------------
  initial begin
    rc_tick  = 1'b0;
    osc_tick = 1'b1;
    forever begin
      @(negedge clk);
      rc_tick = ~rc_tick;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic hold_len(output int n);
    n = 0;
    while (core_rst && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_por();
    @(negedge clk); por_pulse = 1'b1;
    @(negedge clk); por_pulse = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake_req = 1'b1;
    @(negedge clk); wake_req = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic dip(input int cycles);
    @(negedge clk); supply_ok = 1'b0;
    repeat (cycles) @(negedge clk);
    supply_ok = 1'b1;
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  // ---------------- scenarios ----------------
  initial begin
    int len;
    int highs;
    rst_n = 1'b0; por_pulse = 1'b0; supply_ok = 1'b1; wake_req = 1'b0;
    cfg_bod_en = 1'b1; cfg_pwrt_off = 1'b0; cfg_osc_mode = 3'd3; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    check("R12", "core_rst in reset", int'(core_rst), 1);
    check("R12", "flag_por in reset", int'(flag_por), 1);
    check("R12", "flag_bor in reset", int'(flag_bor), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", "core_rst during sync", int'(core_rst), 1);
    hold_len(len);
    check_range("R2", "power-up hold after reset", len, 2*P - 1, 2*P + 3);

    // R2 + R1: power-on pulse with timer enabled, RC mode
    pulse_por();
    check("R1", "core_rst after por", int'(core_rst), 1);
    hold_len(len);
    check_range("R2", "power-up hold after por", len, 2*P - 1, 2*P);
    check("R11", "flag_por set", int'(flag_por), 1);
    pulse_clr();
    check("R11", "flag_por cleared", int'(flag_por), 0);

    // R3 / R5: bypassed timer, non-crystal modes
    cfg_pwrt_off = 1'b1;
    pulse_por(); hold_len(len);
    check("R3", "bypassed hold mode 3", len, 1);
    cfg_osc_mode = 3'd4;
    pulse_por(); hold_len(len);
    check("R5", "bypassed hold mode 4", len, 1);

    // R4: crystal modes add the oscillator delay
    cfg_osc_mode = 3'd1;
    pulse_por(); hold_len(len);
    check("R4", "oscillator delay mode 1", len, 1 + O);
    cfg_osc_mode = 3'd2;
    pulse_por(); hold_len(len);
    check("R4", "oscillator delay mode 2", len, 1 + O);

    // R10: wake requests
    cfg_osc_mode = 3'd0;
    pulse_wake(); hold_len(len);
    check("R10", "wake hold mode 0", len, O);
    cfg_osc_mode = 3'd5;
    pulse_wake(); hold_len(len);
    check("R10", "wake ignored mode 5", len, 0);

    // R6: filter length
    cfg_pwrt_off = 1'b0;
    cfg_osc_mode = 3'd3;
    pulse_clr();
    dip(F - 1);
    check("R6", "short dip core_rst", int'(core_rst), 0);
    check("R6", "short dip flag_bor", int'(flag_bor), 0);
    @(negedge clk); supply_ok = 1'b0;
    repeat (F) @(negedge clk);
    check("R6", "long dip core_rst", int'(core_rst), 1);
    check("R6", "long dip flag_bor", int'(flag_bor), 1);

    // R8: hold while low, no oscillator delay after brown-out
    cfg_osc_mode = 3'd1;
    repeat (20) @(negedge clk);
    check("R8", "held while supply low", int'(core_rst), 1);
    supply_ok = 1'b1;
    @(negedge clk);
    hold_len(len);
    check_range("R8", "hold after recovery, no osc delay", len, 2*P - 1, 2*P + 1);

    // R9: dip during the power-up delay restarts it
    cfg_osc_mode = 3'd3;
    dip(F);
    @(negedge clk);
    repeat (P) @(negedge clk);
    check("R9", "still in power-up delay", int'(core_rst), 1);
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    @(negedge clk);
    hold_len(len);
    check_range("R9", "full delay after restart", len, 2*P - 1, 2*P + 1);

    // R7: brown-out detection disabled
    pulse_clr();
    cfg_bod_en = 1'b0;
    @(negedge clk); supply_ok = 1'b0;
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (core_rst) highs++;
    end
    supply_ok = 1'b1;
    check("R7", "cycles in reset with detection off", highs, 0);
    check("R7", "flag_bor with detection off", int'(flag_bor), 0);
    cfg_bod_en = 1'b1;

    // R11: set wins over clear
    @(negedge clk); por_pulse = 1'b1; flag_clr = 1'b1;
    @(negedge clk); por_pulse = 1'b0; flag_clr = 1'b0;
    check("R11", "set beats clear", int'(flag_por), 1);
    hold_len(len);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule